// File: doc/BRIEF.md
# SRAM Address and Data Line Test Sequencer

This block is a synchronous controller that exercises an external asynchronous static RAM of 2^ADDR_W words by DATA_W bits (256 x 4 by default). It connects to the RAM's address lines, data-in lines, data-out lines, active-low write strobe, active-low output enable and two chip selects, one active high and one active low. A pulse on `start_i` runs a fixed list of steps. Each step is either a write or a read and lasts `CYC_CLKS` system clocks. On a read step the RAM output is compared with an expected word `SAMPLE_CLK` clocks into the step.

The step list checks the address and data lines with address zero and the walking-one addresses. Each walking-one address is read before it is overwritten with the complementary pattern, so that a shorted or open address line appears as an early overwrite. The list then checks that a write is ignored when either chip select alone is deasserted. Last, it checks that the data bus floats to all ones through the board pull-ups when output enable is deasserted. The run stops at the first mismatch and records the step index, the expected word and the observed word.

Top module: `sram_line_tester`

## Requirements
- R1: After reset and whenever no run is active, the RAM pins sit at address 0, data-in 0, write strobe high, output enable low (active), high select 1 and low select 0. `busy_o`, `done_o` and `pass_o` are 0.
- R2: Steps 0 to ADDR_W write pattern A to address 0 and then to the one-hot addresses in ascending order (1, 2, 4 … 2^(ADDR_W-1)). Pattern A has bit i set when i is even (4'b0101 by default).
- R3: Steps ADDR_W+1 to 3*ADDR_W+2 visit the same nine addresses in the same order as pairs. Each pair is a read that expects pattern A, followed by a write of pattern B (the inverse of A, 4'b1010) to that address.
- R4: Steps 3*ADDR_W+3 to 4*ADDR_W+3 read the nine addresses again in the same order and expect pattern B.
- R5: During a write step the write strobe is low exactly for step ticks CYC_CLKS/4 through CYC_CLKS-CYC_CLKS/4-1, counting the first tick as 0. Address, data and selects stay constant for the whole step. The strobe is never low on a read step or outside a run.
- R6: Two chip-select sub-tests follow, low select first and then high select. Each writes 0 to address 0, reads it back as 0, writes all ones with only that one select deasserted, and reads address 0 again expecting 0. The two selects are never both deasserted at once.
- R7: The final sub-test writes 0 to address 0 and reads it back as 0. It then reads with output enable high and expects all ones, which is the pulled-up floating bus. A write never occurs while output enable is high.
- R8: Each step lasts CYC_CLKS clocks. A full passing run of 4*ADDR_W+15 steps raises `done_o` 47*CYC_CLKS clocks after the clock edge that samples `start_i` with default parameters. The RAM output is sampled at tick SAMPLE_CLK of read steps only.
- R9: `busy_o` is high from the edge after `start_i` until the run ends. `done_o` is a single-clock pulse at the end of the run. A `start_i` pulse seen while busy is ignored.
- R10: On the first read mismatch the run stops at once. `done_o` pulses, `pass_o` stays 0, and `fail_step_o`, `fail_exp_o` and `fail_obs_o` hold the step index, the expected word and the observed word.
- R11: `pass_o` and the fail fields hold their values after a run until the next accepted start, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test run (ignored while busy) |
| mem_dout_i | input | DATA_W | RAM data output bus, pulled up on the board |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_din_o | output | DATA_W | RAM write data |
| mem_we_no | output | 1 | RAM write strobe, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_cs_hi_o | output | 1 | RAM chip select, active high |
| mem_cs_lo_no | output | 1 | RAM chip select, active low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-clock pulse at the end of a run |
| pass_o | output | 1 | Last run completed with no mismatch |
| fail_step_o | output | STEP_W | Index of the first failing step |
| fail_exp_o | output | DATA_W | Expected word at the failing step |
| fail_obs_o | output | DATA_W | Observed word at the failing step |

## Verification
The hardest paths to reach are the stop-on-mismatch paths, because a healthy RAM never produces them. The bench's RAM model has three switchable faults. One folds the top address line onto the bottom half, so the walking-one read of the highest address returns B instead of A. One accepts writes whatever the selects are, so the chip-select readback returns all ones. One keeps driving the bus with output enable high, so the floating-bus read returns zero. Each fault must stop the run at its own step with its own expected and observed words. A stray start during a run and a clean run after a failed one confirm that the result fields clear and hold as required.

// File: rtl/sltest_pkg.sv
package sltest_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

  // write strobe low window inside one step
  function automatic logic we_window(input int tick, input int cyc);
    return (tick >= cyc / 4) && (tick < cyc - cyc / 4);
  endfunction
endpackage

// File: rtl/sltest_step_rom.sv
module sltest_step_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] step_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] exp_o,
  output logic              cs_hi_o,
  output logic              cs_lo_no,
  output logic              oe_no
);
  localparam int NW    = ADDR_W + 1;
  localparam int END_A = NW;
  localparam int END_B = 3 * NW;
  localparam int END_C = 4 * NW;
  localparam int END_S = END_C + 8;

  logic [DATA_W-1:0] pat_a;
  logic [DATA_W-1:0] pat_b;

  for (genvar g = 0; g < DATA_W; g++) begin : g_pat
    assign pat_a[g] = ((g % 2) == 0);
  end
  assign pat_b = ~pat_a;

  function automatic logic [ADDR_W-1:0] walk(input int w);
    return (w == 0) ? '0 : (ADDR_W'(1) << (w - 1));
  endfunction

  always_comb begin
    int s;
    int j;
    s        = int'(step_i);
    j        = 0;
    wr_o     = 1'b0;
    addr_o   = '0;
    data_o   = '0;
    exp_o    = '0;
    cs_hi_o  = 1'b1;
    cs_lo_no = 1'b0;
    oe_no    = 1'b0;
    if (s < END_A) begin
      wr_o   = 1'b1;
      addr_o = walk(s);
      data_o = pat_a;
    end else if (s < END_B) begin
      j      = s - END_A;
      addr_o = walk(j / 2);
      if ((j % 2) == 0) exp_o = pat_a;
      else begin
        wr_o   = 1'b1;
        data_o = pat_b;
      end
    end else if (s < END_C) begin
      addr_o = walk(s - END_B);
      exp_o  = pat_b;
    end else if (s < END_S) begin
      j = (s - END_C) % 4;
      if (j == 0) wr_o = 1'b1;
      if (j == 2) begin
        wr_o   = 1'b1;
        data_o = '1;
        if (((s - END_C) / 4) == 0) cs_lo_no = 1'b1;
        else                        cs_hi_o  = 1'b0;
      end
    end else begin
      j = s - END_S;
      if (j == 0) wr_o = 1'b1;
      if (j == 2) begin
        exp_o = '1;
        oe_no = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sltest_timer.sv
module sltest_timer #(
  parameter int CYC = 50,
  localparam int TW = $clog2(CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [TW-1:0] tick_o,
  output logic          wrap_o
);
  logic [TW-1:0] tick_q;

  assign wrap_o = (tick_q == TW'(CYC - 1));
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_q <= '0;
    else if (clr_i)  tick_q <= '0;
    else if (en_i)   tick_q <= wrap_o ? '0 : tick_q + 1'b1;
  end

  assert_tick_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tick_q) < CYC);
endmodule

// File: rtl/sram_line_tester.sv
module sram_line_tester #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 4,
  parameter int CYC_CLKS   = 50,
  parameter int SAMPLE_CLK = 40,
  localparam int STEPS     = 4 * (ADDR_W + 1) + 11,
  localparam int STEP_W    = $clog2(STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mem_dout_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_din_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_cs_hi_o,
  output logic              mem_cs_lo_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [STEP_W-1:0] fail_step_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_obs_o
);
  import sltest_pkg::*;

  localparam int TICK_W = $clog2(CYC_CLKS);

  run_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [TICK_W-1:0] tick;
  logic              wrap;
  logic              go;

  logic              s_wr, s_cs_hi, s_cs_lo_n, s_oe_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data, s_exp;

  logic              mismatch;
  logic              last_step;

  sltest_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_rom (
    .step_i  (step_q),
    .wr_o    (s_wr),
    .addr_o  (s_addr),
    .data_o  (s_data),
    .exp_o   (s_exp),
    .cs_hi_o (s_cs_hi),
    .cs_lo_no(s_cs_lo_n),
    .oe_no   (s_oe_n)
  );

  sltest_timer #(.CYC(CYC_CLKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (go),
    .en_i  (state_q == ST_RUN),
    .tick_o(tick),
    .wrap_o(wrap)
  );

  assign go        = (state_q == ST_IDLE) && start_i;
  assign last_step = (step_q == STEP_W'(STEPS - 1));
  assign mismatch  = (state_q == ST_RUN) && !s_wr &&
                     (tick == TICK_W'(SAMPLE_CLK)) && (mem_dout_i != s_exp);
  assign busy_o    = (state_q == ST_RUN);

  // sequencing and result capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_step_o <= '0;
      fail_exp_o  <= '0;
      fail_obs_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q     <= ST_RUN;
          step_q      <= '0;
          pass_o      <= 1'b0;
          fail_step_o <= '0;
          fail_exp_o  <= '0;
          fail_obs_o  <= '0;
        end
      end else if (mismatch) begin
        state_q     <= ST_IDLE;
        done_o      <= 1'b1;
        fail_step_o <= step_q;
        fail_exp_o  <= s_exp;
        fail_obs_o  <= mem_dout_i;
      end else if (wrap) begin
        if (last_step) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          pass_o  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  // registered pad drivers: no glitches on the async RAM strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o   <= '0;
      mem_din_o    <= '0;
      mem_we_no    <= 1'b1;
      mem_oe_no    <= 1'b0;
      mem_cs_hi_o  <= 1'b1;
      mem_cs_lo_no <= 1'b0;
    end else if (state_q == ST_RUN) begin
      mem_addr_o   <= s_addr;
      mem_din_o    <= s_data;
      mem_we_no    <= !(s_wr && we_window(int'(tick), CYC_CLKS));
      mem_oe_no    <= s_oe_n;
      mem_cs_hi_o  <= s_cs_hi;
      mem_cs_lo_no <= s_cs_lo_n;
    end else begin
      mem_addr_o   <= '0;
      mem_din_o    <= '0;
      mem_we_no    <= 1'b1;
      mem_oe_no    <= 1'b0;
      mem_cs_hi_o  <= 1'b1;
      mem_cs_lo_no <= 1'b0;
    end
  end

  assert_strobe_pins_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> ($stable(mem_addr_o) && $stable(mem_din_o) && $stable(mem_cs_hi_o)));

  assert_no_strobe_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mem_we_no);

  assert_one_select_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_cs_hi_o && mem_cs_lo_no));

  assert_no_write_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_oe_no |-> mem_we_no);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_result_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_step_o) && $stable(fail_obs_o)));
endmodule

// File: tb/sram_line_tester_test.sv
module sram_line_tester_test;
  localparam int AW   = 8;
  localparam int DW   = 4;
  localparam int CYC  = 50;
  localparam int SMP  = 40;
  localparam int NSTP = 4 * (AW + 1) + 11;
  localparam int SW   = $clog2(NSTP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] dout;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          we_n, oe_n, cs_hi, cs_lo_n, busy, done, pass;
  logic [SW-1:0] fstep;
  logic [DW-1:0] fexp, fobs;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sram_line_tester #(.ADDR_W(AW), .DATA_W(DW), .CYC_CLKS(CYC), .SAMPLE_CLK(SMP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mem_dout_i(dout),
    .mem_addr_o(addr), .mem_din_o(din), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_cs_hi_o(cs_hi), .mem_cs_lo_no(cs_lo_n), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_step_o(fstep), .fail_exp_o(fexp), .fail_obs_o(fobs)
  );

  // ---------------- RAM model with pull-ups and injectable faults
  logic [DW-1:0] ram [256];
  bit f_alias = 0, f_ign_cs = 0, f_oe_stuck = 0;
  logic          sel;
  logic [AW-1:0] eff;
  assign sel  = cs_hi && !cs_lo_n;
  assign eff  = f_alias ? {1'b0, addr[AW-2:0]} : addr;
  assign dout = ((sel && we_n && !oe_n) || (sel && we_n && f_oe_stuck)) ? ram[eff] : '1;

  always @(negedge clk)
    if ((sel || f_ign_cs) && !we_n) ram[eff] <= din;

  // ---------------- step list built from the requirements
  bit            q_wr[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$], q_exp[$];
  bit            q_csh[$], q_csln[$], q_oen[$];

  task automatic push(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] e,
                      bit csh, bit csln, bit oen);
    q_wr.push_back(wr); q_addr.push_back(a); q_data.push_back(d); q_exp.push_back(e);
    q_csh.push_back(csh); q_csln.push_back(csln); q_oen.push_back(oen);
  endtask

  function automatic logic [AW-1:0] walk_a(int w);
    return (w == 0) ? '0 : AW'(1) << (w - 1);
  endfunction

  function automatic string tag_of(int s);
    if (s < 9)  return "R2";
    if (s < 27) return "R3";
    if (s < 36) return "R4";
    if (s < 44) return "R6";
    return "R7";
  endfunction

  // ---------------- cycle reference model
  bit            m_run = 0, m_done = 0, m_pass = 0;
  int            m_step = 0, m_tick = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_din = '0, m_fexp = '0, m_fobs = '0;
  bit            m_we_n = 1, m_oe_n = 0, m_csh = 1, m_csln = 0;
  int            m_fstep = 0;

  task automatic chk(string tag, longint act, longint exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_pass = 0; m_step = 0; m_tick = 0;
      m_addr = '0; m_din = '0; m_we_n = 1; m_oe_n = 0; m_csh = 1; m_csln = 0;
      m_fstep = 0; m_fexp = '0; m_fobs = '0;
    end else begin
      // compare every clock
      chk({tag_of(m_step), " pins"}, {addr, din, oe_n, cs_hi, cs_lo_n},
          {m_addr, m_din, m_oe_n, m_csh, m_csln});
      chk("R5 strobe", we_n, m_we_n);
      chk("R9 busy/done", {busy, done}, {m_run, m_done});
      chk("R10 result", {pass, fstep, fexp, fobs}, {m_pass, SW'(m_fstep), m_fexp, m_fobs});
      // advance to the state after the next rising edge
      m_done = 0;
      if (m_run) begin
        m_addr = q_addr[m_step]; m_din = q_data[m_step]; m_oe_n = q_oen[m_step];
        m_csh  = q_csh[m_step];  m_csln = q_csln[m_step];
        m_we_n = !(q_wr[m_step] && m_tick >= CYC / 4 && m_tick < CYC - CYC / 4);
        if (!q_wr[m_step] && m_tick == SMP && dout != q_exp[m_step]) begin
          m_run = 0; m_done = 1; m_fstep = m_step; m_fexp = q_exp[m_step]; m_fobs = dout;
        end else if (m_tick == CYC - 1) begin
          m_tick = 0;
          if (m_step == NSTP - 1) begin m_run = 0; m_done = 1; m_pass = 1; end
          else m_step++;
        end else m_tick++;
      end else begin
        m_addr = '0; m_din = '0; m_we_n = 1; m_oe_n = 0; m_csh = 1; m_csln = 0;
        if (start) begin
          m_run = 1; m_step = 0; m_tick = 0; m_pass = 0;
          m_fstep = 0; m_fexp = '0; m_fobs = '0;
        end
      end
    end
  end

  // ---------------- stimulus helpers
  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!done && n < 3000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog: actual=no done expected=done within 3000 clocks");
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL R9 global watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] pa, pb;
    pa = 4'b0101; pb = 4'b1010;
    for (int i = 0; i < 256; i++) ram[i] = '0;
    for (int w = 0; w <= AW; w++) push(1, walk_a(w), pa, '0, 1, 0, 0);
    for (int w = 0; w <= AW; w++) begin
      push(0, walk_a(w), '0, pa, 1, 0, 0);
      push(1, walk_a(w), pb, '0, 1, 0, 0);
    end
    for (int w = 0; w <= AW; w++) push(0, walk_a(w), '0, pb, 1, 0, 0);
    for (int c = 0; c < 2; c++) begin
      push(1, '0, '0, '0, 1, 0, 0);
      push(0, '0, '0, '0, 1, 0, 0);
      push(1, '0, '1, '0, (c == 1) ? 1'b0 : 1'b1, (c == 0), 0);
      push(0, '0, '0, '0, 1, 0, 0);
    end
    push(1, '0, '0, '0, 1, 0, 0);
    push(0, '0, '0, '0, 1, 0, 0);
    push(0, '0, '0, '1, 1, 0, 1);

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle pins", {addr, din, we_n, oe_n, cs_hi, cs_lo_n}, {8'h00, 4'h0, 4'b1010});
    chk("R1 idle status", {busy, done, pass}, 3'b000);

    // clean run, stray start mid-run (R9), step length (R8)
    pulse_start();
    repeat (100) @(posedge clk);
    #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk("R9 busy kept", busy, 1);
    wait_done(n);
    // done is seen 47*CYC edges after the sampling edge; 100+1 clocks elapsed before wait
    chk("R8 run length", n + 102, NSTP * CYC + 1);
    chk("R4 clean pass", pass, 1);
    chk("R2 no fail step", fstep, 0);
    repeat (20) @(negedge clk);
    chk("R11 pass held", pass, 1);

    // folded address line: highest walking address reads B early
    f_alias = 1;
    pulse_start(); wait_done(n);
    chk("R10 alias pass", pass, 0);
    chk("R3 alias step", fstep, 25);
    chk("R10 alias exp", fexp, pa);
    chk("R10 alias obs", fobs, pb);
    repeat (3) @(negedge clk);
    chk("R1 idle after stop", {addr, we_n, oe_n, busy}, {8'h00, 3'b100});
    chk("R11 fail held", fstep, 25);
    f_alias = 0;

    // selects ignored by RAM
    f_ign_cs = 1;
    pulse_start(); wait_done(n);
    chk("R6 cs step", fstep, 39);
    chk("R6 cs obs", {pass, fexp, fobs}, {1'b0, 4'h0, 4'hF});
    f_ign_cs = 0;

    // bus not released with output enable high
    f_oe_stuck = 1;
    pulse_start(); wait_done(n);
    chk("R7 oe step", fstep, 46);
    chk("R7 oe obs", {pass, fexp, fobs}, {1'b0, 4'hF, 4'h0});
    f_oe_stuck = 0;

    // new start clears the held result
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R11 cleared", {busy, pass, fstep}, {1'b1, 1'b0, 6'd0});
    wait_done(n);
    chk("R11 rerun pass", pass, 1);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule